// File: doc/BRIEF.md
# Coarse-Grained Stall-Triggered Thread Switcher

This block steers a pipeline that carries instructions from a single hardware thread at a time. The running thread keeps the pipeline until it reports a costly event such as a second-level cache miss. At that point the block marks the thread as waiting on memory. It drains the pipeline, either by flushing it or by freezing it. It then picks the next thread that is not waiting, in round-robin order, and points fetch at that thread's saved PC. Short stalls never move the pipeline to another thread. The running thread sits through them.

Every thread keeps its own PC and register state in hardware, so a switch needs no memory traffic. The cost of a switch is the refill. After the redirect, the new thread issues but cannot complete an instruction until the pipeline has advanced through its full depth. When every thread is waiting on a miss, the pipeline idles until a miss-return event releases one of them.

Top module: `cgmt_switcher`

## Requirements
- R1: After reset, thread 0 is active, issue_en and complete_en are high, and flush, freeze, idle and redirect_valid are low.
- R2: A miss_valid seen while the pipeline runs puts the block in a drain cycle on the next clock. In that cycle issue_en and complete_en are low and the pending flag of the missing thread is set. With DRAIN_BY_FLUSH=1, flush is high for exactly that one cycle.
- R3: short_stall never causes a switch and never changes active_tid, flush or freeze. During refill, each cycle with short_stall high does not count toward the refill length.
- R4: The next thread is the first one, counting upward from the current index modulo NUM_THREADS, whose pending flag is clear. In the cycle where redirect_valid pulses high for one clock, active_tid already shows that thread.
- R5: redirect_pc is the oldest_pc value captured in the cycle the thread's miss was accepted. For a thread that has never run, it is RESET_PC_BASE + tid*RESET_PC_STRIDE.
- R6: miss_ret_valid clears the pending flag of miss_ret_tid. A pending thread is never selected. If a thread's miss is accepted in the same cycle as a return for that thread, the flag ends up set.
- R7: When no thread is eligible, idle is high and issue_en and complete_en are low. The first clock that sees a cleared pending flag moves the block on to a redirect.
- R8: From the redirect cycle, issue_en is high and complete_en stays low for PIPE_DEPTH cycles without short_stall. complete_en then goes high.
- R9: A miss_valid in a drain cycle or during refill is held, not acted on. It is taken as a miss of the running thread in the first running cycle, so one running cycle occurs before the next drain.
- R10: miss_valid while idle is ignored.
- R11: With DRAIN_BY_FLUSH=0, freeze is high in drain and idle cycles and flush is never high. With DRAIN_BY_FLUSH=1, freeze is never high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Costly stall (long miss) by the running thread |
| miss_ret_valid | input | 1 | A long miss has returned |
| miss_ret_tid | input | TID_W | Thread whose miss returned |
| short_stall | input | 1 | Short pipeline stall |
| oldest_pc | input | PC_W | PC of the running thread's oldest unretired instruction |
| active_tid | output | TID_W | Thread owning the pipeline |
| issue_en | output | 1 | Fetch and issue allowed |
| complete_en | output | 1 | Completion of instructions allowed |
| flush | output | 1 | Discard in-flight instructions |
| freeze | output | 1 | Hold pipeline contents |
| idle | output | 1 | No eligible thread |
| redirect_valid | output | 1 | Fetch redirect pulse |
| redirect_pc | output | PC_W | Fetch target for the new thread |

## Verification
The embedded assertions check these properties on every clock. A miss in a running cycle must stop issue on the next cycle. A flush pulse lasts one cycle. A redirect never names a thread that is waiting on memory. Completion stays off during the redirect cycle and while idle. Short stalls leave the active thread and the drain controls alone. Other behaviour only shows up across whole scenarios, and the bench scenarios cover it. These are the round-robin order across wrap-around, the saved PC returned when a thread is resumed, the refill length stretched by short stalls, the held miss that starts a second switch one running cycle after refill, and the ignored miss while all threads wait.

// File: rtl/cgmt_pkg.sv
package cgmt_pkg;
   typedef enum logic [1:0] {
      PH_RUN    = 2'd0,
      PH_DRAIN  = 2'd1,
      PH_WAIT   = 2'd2,
      PH_REFILL = 2'd3
   } phase_e;
endpackage

// File: rtl/cgmt_ctx.sv
// Per-thread context: miss-pending flag and saved resume PC.
module cgmt_ctx #(
   parameter int              NUM_THREADS     = 4,
   parameter int              PC_W            = 32,
   parameter int              TID_W           = 2,
   parameter logic [PC_W-1:0] RESET_PC_BASE   = 'h1000,
   parameter logic [PC_W-1:0] RESET_PC_STRIDE = 'h100
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   set_en,
   input  logic [TID_W-1:0]       set_tid,
   input  logic [PC_W-1:0]        set_pc,
   input  logic                   clr_en,
   input  logic [TID_W-1:0]       clr_tid,
   input  logic [TID_W-1:0]       rd_tid,
   output logic [PC_W-1:0]        rd_pc,
   output logic [NUM_THREADS-1:0] pend
);
   logic [PC_W-1:0] pc_q [NUM_THREADS];

   for (genvar g = 0; g < NUM_THREADS; g++) begin : g_thr
      logic hit_set, hit_clr;
      assign hit_set = set_en && (set_tid == TID_W'(g));
      assign hit_clr = clr_en && (clr_tid == TID_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend[g] <= 1'b0;
            pc_q[g] <= RESET_PC_BASE + PC_W'(g) * RESET_PC_STRIDE;
         end else begin
            if (hit_set) begin
               pend[g] <= 1'b1;
               pc_q[g] <= set_pc;
            end else if (hit_clr) begin
               pend[g] <= 1'b0;
            end
         end
      end

      // R6: a flag only rises because a miss was accepted
      assert_pend_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pend[g]) |-> $past(set_en));
   end

   assign rd_pc = pc_q[rd_tid];
endmodule

// File: rtl/cgmt_pick.sv
// Round-robin selection of the next non-pending thread after the current one.
module cgmt_pick #(
   parameter int NUM_THREADS = 4,
   parameter int TID_W       = 2
) (
   input  logic [TID_W-1:0]       cur,
   input  logic [NUM_THREADS-1:0] pend,
   output logic                   found,
   output logic [TID_W-1:0]       pick
);
   always_comb begin
      found = 1'b0;
      pick  = cur;
      for (int k = 1; k <= NUM_THREADS; k++) begin
         int idx;
         idx = (int'(cur) + k) % NUM_THREADS;
         if (!found && !pend[idx]) begin
            found = 1'b1;
            pick  = TID_W'(idx);
         end
      end
   end
endmodule

// File: rtl/cgmt_refill.sv
// Counts the pipeline advances a new thread needs before it may complete.
module cgmt_refill #(
   parameter int PIPE_DEPTH = 5,
   parameter int CNT_W      = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic step,
   output logic last
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= CNT_W'(PIPE_DEPTH - 1);
      else if (step && cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign last = (cnt_q == '0);

   // R8: a fresh load leaves at least one more refill cycle
   assert_load_not_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !last);
endmodule

// File: rtl/cgmt_switcher.sv
module cgmt_switcher #(
   parameter int              NUM_THREADS     = 4,
   parameter int              PC_W            = 32,
   parameter int              PIPE_DEPTH      = 5,
   parameter bit              DRAIN_BY_FLUSH  = 1'b1,
   parameter logic [PC_W-1:0] RESET_PC_BASE   = 'h1000,
   parameter logic [PC_W-1:0] RESET_PC_STRIDE = 'h100,
   localparam int             TID_W           = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             miss_valid,
   input  logic             miss_ret_valid,
   input  logic [TID_W-1:0] miss_ret_tid,
   input  logic             short_stall,
   input  logic [PC_W-1:0]  oldest_pc,
   output logic [TID_W-1:0] active_tid,
   output logic             issue_en,
   output logic             complete_en,
   output logic             flush,
   output logic             freeze,
   output logic             idle,
   output logic             redirect_valid,
   output logic [PC_W-1:0]  redirect_pc
);
   import cgmt_pkg::*;

   localparam int CNT_W = (PIPE_DEPTH > 2) ? $clog2(PIPE_DEPTH) : 1;

   if (NUM_THREADS < 2) begin : g_chk_threads
      $error("cgmt_switcher: NUM_THREADS must be at least 2");
   end
   if (PIPE_DEPTH < 2) begin : g_chk_depth
      $error("cgmt_switcher: PIPE_DEPTH must be at least 2");
   end
   if (PC_W < 8) begin : g_chk_pc
      $error("cgmt_switcher: PC_W must be at least 8");
   end

   phase_e                 state_q, state_d;
   logic [TID_W-1:0]       act_q;
   logic                   held_q;
   logic                   redir_q;
   logic [PC_W-1:0]        rpc_q;
   logic [NUM_THREADS-1:0] pend;
   logic [PC_W-1:0]        cand_pc;
   logic                   found;
   logic [TID_W-1:0]       nxt_tid;
   logic                   run_miss, picking, take, rf_step, rf_last;

   assign run_miss = (state_q == PH_RUN) && (miss_valid || held_q);
   assign picking  = (state_q == PH_DRAIN) || (state_q == PH_WAIT);
   assign take     = picking && found;
   assign rf_step  = (state_q == PH_REFILL) && !short_stall;

   cgmt_ctx #(
      .NUM_THREADS    (NUM_THREADS),
      .PC_W           (PC_W),
      .TID_W          (TID_W),
      .RESET_PC_BASE  (RESET_PC_BASE),
      .RESET_PC_STRIDE(RESET_PC_STRIDE)
   ) u_ctx (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (run_miss),
      .set_tid(act_q),
      .set_pc (oldest_pc),
      .clr_en (miss_ret_valid),
      .clr_tid(miss_ret_tid),
      .rd_tid (nxt_tid),
      .rd_pc  (cand_pc),
      .pend   (pend)
   );

   cgmt_pick #(
      .NUM_THREADS(NUM_THREADS),
      .TID_W      (TID_W)
   ) u_pick (
      .cur  (act_q),
      .pend (pend),
      .found(found),
      .pick (nxt_tid)
   );

   cgmt_refill #(
      .PIPE_DEPTH(PIPE_DEPTH),
      .CNT_W     (CNT_W)
   ) u_refill (
      .clk  (clk),
      .rst_n(rst_n),
      .load (take),
      .step (rf_step),
      .last (rf_last)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PH_RUN:    if (run_miss) state_d = PH_DRAIN;
         PH_DRAIN,
         PH_WAIT:   state_d = found ? PH_REFILL : PH_WAIT;
         PH_REFILL: if (rf_step && rf_last) state_d = PH_RUN;
         default:   state_d = PH_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= PH_RUN;
         act_q   <= '0;
         held_q  <= 1'b0;
         redir_q <= 1'b0;
         rpc_q   <= '0;
      end else begin
         state_q <= state_d;
         redir_q <= take;
         if (take) begin
            act_q <= nxt_tid;
            rpc_q <= cand_pc;
         end
         if (run_miss)
            held_q <= 1'b0;
         else if (miss_valid && (state_q == PH_DRAIN || state_q == PH_REFILL))
            held_q <= 1'b1;
      end
   end

   assign active_tid     = act_q;
   assign issue_en       = (state_q == PH_RUN) || (state_q == PH_REFILL);
   assign complete_en    = (state_q == PH_RUN);
   assign idle           = (state_q == PH_WAIT);
   assign redirect_valid = redir_q;
   assign redirect_pc    = rpc_q;

   if (DRAIN_BY_FLUSH) begin : g_flush
      assign flush  = (state_q == PH_DRAIN);
      assign freeze = 1'b0;
   end else begin : g_freeze
      assign flush  = 1'b0;
      assign freeze = (state_q == PH_DRAIN) || (state_q == PH_WAIT);
   end

   assert_miss_stops_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (complete_en && miss_valid) |=> !issue_en);

   assert_flush_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !flush);

   assert_short_no_switch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (complete_en && short_stall && !miss_valid && !held_q)
         |=> ($stable(active_tid) && !flush && !freeze));

   assert_pick_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |-> !pend[active_tid]);

   assert_wait_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> (!issue_en && !complete_en && !redirect_valid));

   assert_redirect_no_complete_R8: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |-> (issue_en && !complete_en));
endmodule

// File: tb/cgmt_switcher_test.sv
module cgmt_switcher_test;
   localparam int N     = 4;
   localparam int DEPTH = 5;
   localparam int TW    = 2;
   localparam logic [31:0] BASE   = 32'h1000;
   localparam logic [31:0] STRIDE = 32'h100;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          miss_valid = 1'b0, miss_ret_valid = 1'b0, short_stall = 1'b0;
   logic [TW-1:0] miss_ret_tid = '0;
   logic [31:0]   oldest_pc = '0;

   logic [TW-1:0] active_tid, a_tid_f;
   logic          issue_en, complete_en, flush, freeze, idle, redirect_valid;
   logic          iss_f, cmp_f, fl_f, fz_f, idl_f, rv_f;
   logic [31:0]   redirect_pc, rpc_f;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   cgmt_switcher #(.NUM_THREADS(N), .PC_W(32), .PIPE_DEPTH(DEPTH), .DRAIN_BY_FLUSH(1'b1),
                   .RESET_PC_BASE(BASE), .RESET_PC_STRIDE(STRIDE)) uut (
      .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ret_valid(miss_ret_valid),
      .miss_ret_tid(miss_ret_tid), .short_stall(short_stall), .oldest_pc(oldest_pc),
      .active_tid(active_tid), .issue_en(issue_en), .complete_en(complete_en),
      .flush(flush), .freeze(freeze), .idle(idle), .redirect_valid(redirect_valid),
      .redirect_pc(redirect_pc));

   cgmt_switcher #(.NUM_THREADS(N), .PC_W(32), .PIPE_DEPTH(DEPTH), .DRAIN_BY_FLUSH(1'b0),
                   .RESET_PC_BASE(BASE), .RESET_PC_STRIDE(STRIDE)) uut_frz (
      .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ret_valid(miss_ret_valid),
      .miss_ret_tid(miss_ret_tid), .short_stall(short_stall), .oldest_pc(oldest_pc),
      .active_tid(a_tid_f), .issue_en(iss_f), .complete_en(cmp_f),
      .flush(fl_f), .freeze(fz_f), .idle(idl_f), .redirect_valid(rv_f),
      .redirect_pc(rpc_f));

   // Reference state: 0 run, 1 drain, 2 wait, 3 refill
   int          m_state, m_act, m_cnt;
   bit          m_pend [N];
   logic [31:0] m_pc [N];
   bit          m_held, m_redir;
   logic [31:0] m_rpc;

   task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, got, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_state = 0; m_act = 0; m_cnt = 0; m_held = 0; m_redir = 0; m_rpc = '0;
      for (int i = 0; i < N; i++) begin
         m_pend[i] = 0;
         m_pc[i]   = BASE + 32'(i) * STRIDE;
      end
   endtask

   function automatic int pick_next();
      for (int k = 1; k <= N; k++) begin
         int idx;
         idx = (m_act + k) % N;
         if (!m_pend[idx]) return idx;
      end
      return -1;
   endfunction

   task automatic model_step(bit mv, bit rv, int rt, bit ss, logic [31:0] opc);
      int nx;
      bit run_miss;
      nx = pick_next();
      run_miss = (m_state == 0) && (mv || m_held);
      m_redir = 0;
      case (m_state)
         0: if (run_miss) begin m_state = 1; m_held = 0; end
         1, 2: begin
            if (m_state == 1 && mv) m_held = 1;
            if (nx >= 0) begin
               m_state = 3; m_redir = 1; m_rpc = m_pc[nx]; m_act = nx; m_cnt = DEPTH - 1;
            end else m_state = 2;
         end
         default: begin
            if (mv) m_held = 1;
            if (!ss) begin
               if (m_cnt == 0) m_state = 0; else m_cnt--;
            end
         end
      endcase
      if (rv) m_pend[rt] = 0;
      if (run_miss) begin
         // the thread that missed is the one active before this step
         int who;
         who = (m_redir) ? -1 : m_act;
         if (who >= 0) begin m_pend[who] = 1; m_pc[who] = opc; end
      end
   endtask

   task automatic compare(string ph);
      string tag;
      tag = {" [", ph, "]"};
      chk("R4", {"active_tid", tag}, 64'(active_tid), 64'(m_act));
      chk("R4", {"redirect_valid", tag}, 64'(redirect_valid), 64'(m_redir));
      if (m_redir) chk("R5", {"redirect_pc", tag}, 64'(redirect_pc), 64'(m_rpc));
      chk("R2", {"flush", tag}, 64'(flush), 64'(m_state == 1));
      chk("R11", {"freeze flush-mode", tag}, 64'(freeze), 64'd0);
      chk("R11", {"freeze freeze-mode", tag}, 64'(fz_f), 64'(m_state == 1 || m_state == 2));
      chk("R11", {"flush freeze-mode", tag}, 64'(fl_f), 64'd0);
      chk("R7", {"issue_en", tag}, 64'(issue_en), 64'(m_state == 0 || m_state == 3));
      chk("R8", {"complete_en", tag}, 64'(complete_en), 64'(m_state == 0));
      chk("R7", {"idle", tag}, 64'(idle), 64'(m_state == 2));
   endtask

   task automatic cycle(string ph, bit mv, bit rv, int rt, bit ss, logic [31:0] opc);
      compare(ph);
      miss_valid = mv; miss_ret_valid = rv; miss_ret_tid = TW'(rt);
      short_stall = ss; oldest_pc = opc;
      model_step(mv, rv, rt, ss, opc);
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic quiet(string ph, int n);
      for (int i = 0; i < n; i++) cycle(ph, 0, 0, 0, 0, 32'hDEAD_0000 + 32'(i));
   endtask

   initial begin
      bit done;
      done = 0;
      void'($urandom(32'h5EED_1234));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1", "active_tid", 64'(active_tid), 64'd0);
      chk("R1", "issue_en", 64'(issue_en), 64'd1);
      chk("R1", "complete_en", 64'(complete_en), 64'd1);
      chk("R1", "flush", 64'(flush), 64'd0);
      chk("R1", "freeze", 64'(fz_f), 64'd0);
      chk("R1", "idle", 64'(idle), 64'd0);
      chk("R1", "redirect_valid", 64'(redirect_valid), 64'd0);

      // R3: short stalls while running change nothing
      for (int i = 0; i < 6; i++) cycle("R3", 0, 0, 0, 1, 32'h0);
      chk("R3", "active after short stalls", 64'(active_tid), 64'd0);

      // R2/R4: miss on thread 0, switch to thread 1 at its reset PC
      cycle("R2", 1, 0, 0, 0, 32'h2468);
      quiet("R4", 3);
      chk("R4", "switched thread", 64'(active_tid), 64'd1);
      quiet("R8", 6);

      // R3: short stalls stretch the refill
      cycle("R2", 1, 0, 0, 0, 32'h3000);
      quiet("R3", 2);
      for (int i = 0; i < 4; i++) cycle("R3", 0, 0, 0, (i % 2) == 0, 32'h0);
      quiet("R8", 6);
      chk("R4", "thread after second switch", 64'(active_tid), 64'd2);

      // R9: miss during refill is held and triggers a later switch
      cycle("R2", 1, 0, 0, 0, 32'h3300);
      quiet("R9", 3);
      cycle("R9", 1, 0, 0, 0, 32'h3600);
      quiet("R9", 8);
      chk("R7", "all threads pending gives idle", 64'(idle), 64'd1);

      // R10: miss while idle ignored; R6/R5: return releases thread 1 at saved PC
      for (int i = 0; i < 3; i++) cycle("R10", 1, 0, 0, 0, 32'h7777);
      chk("R10", "still idle after ignored miss", 64'(idle), 64'd1);
      cycle("R6", 0, 1, 1, 0, 32'h0);
      cycle("R7", 0, 0, 0, 0, 32'h0);
      chk("R5", "resume pc of thread 1", 64'(redirect_pc), 64'h3000);
      chk("R4", "resumed thread", 64'(active_tid), 64'd1);
      quiet("R8", 6);

      // R6: return for the running thread in the same cycle as its miss
      cycle("R6", 1, 1, 1, 0, 32'h4400);
      quiet("R6", 3);
      cycle("R6", 0, 1, 0, 0, 32'h0);
      quiet("R6", 4);
      chk("R6", "released thread chosen", 64'(active_tid), 64'd0);
      chk("R5", "saved pc of thread 0", 64'(redirect_pc), 64'h2468);
      quiet("R8", 6);
      for (int t = 0; t < N; t++) cycle("R6", 0, 1, t, 0, 32'h0);

      // Random mix
      for (int i = 0; i < 3000; i++) begin
         bit mv, rv, ss;
         mv = ($urandom_range(99) < 8);
         rv = ($urandom_range(99) < 12);
         ss = ($urandom_range(99) < 20);
         cycle("R4", mv, rv, int'($urandom_range(N - 1)), ss, $urandom());
      end
      compare("R4");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule